// File: doc/BRIEF.md
# Integer-to-Float Conversion Unit

This block turns an integer operand into an IEEE-754 half- or single-precision value. A decoded control word goes with each 32-bit source word. The control word names the integer width (8, 16 or 32 bits), whether the integer is signed, which byte or halfword of the word to use, the magnitude and negate modifiers, the rounding direction and the float format of the result. Each accepted operation produces a registered result word and a valid strobe one clock later. Operations are accepted every cycle.

The sign and magnitude modifiers handle the most negative integer of each width in a specific way. Taking the magnitude leaves that value as it is. When negate is used alone on a signed source, the sign of that value is kept. Such inputs therefore still convert to a negative float. Encodings that the unit does not support raise an illegal-operand flag and give a zero result. These are 64-bit sources, double-precision or undefined result formats, and selectors that do not suit the source width.

Top module: `i2f_unit`

## Requirements
- R1: When `inValid` is sampled high on a rising clock edge, `outValid`, `result` and `illegalOp` for that operation appear after that edge and hold for one cycle. A cycle without `inValid` gives `outValid` low. Reset clears all three outputs.
- R2: With `srcFmt` = 0 the operand is 8 bits taken from bit `sel`*8 of `srcWord`. It is sign-extended when `isSigned` is 1 and zero-extended otherwise.
- R3: With `srcFmt` = 1 the operand is 16 bits taken from bit `sel`*8, and only `sel` values 0 and 2 are legal. With `srcFmt` = 2 the operand is the whole word, and only `sel` = 0 is legal.
- R4: `illegalOp` is 1 and `result` is 0 when any of these holds: `srcFmt` = 3; `dstFmt` = 0 or 3; `srcFmt` = 1 with an odd `sel`; `srcFmt` = 2 with a nonzero `sel`.
- R5: With `absMod` set, a negative extended operand is replaced by its magnitude. A 32-bit operand is only negative when `isSigned` is set. The most negative value of the width (-128, -32768 or -2^31) is left unchanged.
- R6: With `negMod` set and either `absMod` set or `isSigned` clear, the sign bit of the float result is inverted.
- R7: With `negMod` set, `isSigned` set and `absMod` clear, the sign bit is inverted unless the extended operand equals the most negative value of its width. In that case the result stays negative.
- R8: An operand that cannot be represented exactly is rounded according to `rndMode`. The codes are 0 = nearest with ties to even, 1 = toward minus infinity, 2 = toward plus infinity and 3 = toward zero. The direction applies to the value before negation.
- R9: `dstFmt` = 1 selects half precision, placed in `result[15:0]` with `result[31:16]` = 0. `dstFmt` = 2 selects single precision in all 32 bits.
- R10: A half-precision magnitude above the largest finite value (65504) becomes infinity (0x7C00 magnitude) when the rounding mode rounds away from zero for that sign. This is always the case in mode 0. Otherwise it becomes 0x7BFF.
- R11: A zero operand gives +0.0 (all result bits zero). With `negMod` set it gives -0.0 (only the sign bit of the chosen format set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| srcWord | input | 32 | Source integer word |
| srcFmt | input | 2 | Integer width code: 0 = 8, 1 = 16, 2 = 32, 3 = 64 (illegal) |
| isSigned | input | 1 | Treat the operand as two's complement |
| sel | input | 2 | Byte offset of the operand within the word |
| absMod | input | 1 | Take the magnitude of the operand |
| negMod | input | 1 | Negate the converted value |
| rndMode | input | 2 | Rounding direction code |
| dstFmt | input | 2 | Float format code: 1 = half, 2 = single, 0/3 illegal |
| outValid | output | 1 | Result valid strobe |
| result | output | 32 | Converted float word |
| illegalOp | output | 1 | Operation used an unsupported encoding |

## Verification
The bench applies every combination of control fields to a set of source words. The words are chosen to hit extreme values, such as the most negative and largest values of each width and the byte and halfword patterns where sign extension differs from zero extension. They also include values that round exactly halfway, just above and just below the half-precision range, and that carry into the next exponent when rounded up. A design that dropped the most-negative exception would return a positive float for -128 under abs or negate. A design with a wrong tie rule would be off by one unit in the last place on the halfway words. A design with wrong overflow handling would return infinity where the largest finite value is required, or the reverse. Wrong selector decoding would either convert the wrong byte or fail to flag odd halfword offsets.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  localparam logic [1:0] SRC_B8  = 2'd0;
  localparam logic [1:0] SRC_B16 = 2'd1;
  localparam logic [1:0] SRC_B32 = 2'd2;
  localparam logic [1:0] SRC_B64 = 2'd3;

  localparam logic [1:0] DST_HALF   = 2'd1;
  localparam logic [1:0] DST_SINGLE = 2'd2;

  localparam logic [1:0] RND_NEAR = 2'd0;
  localparam logic [1:0] RND_DOWN = 2'd1;
  localparam logic [1:0] RND_UP   = 2'd2;
  localparam logic [1:0] RND_ZERO = 2'd3;

  typedef struct packed {
    logic width8;
    logic width16;
    logic signExt;
    logic doAbs;
    logic negAlways;
    logic negUnlessMin;
    logic halfOut;
    logic illegal;
  } i2fCtrl_t;
endpackage

// File: rtl/i2f_ctrl.sv
module i2f_ctrl
  import i2f_pkg::*;
(
  input  logic [1:0] srcFmt,
  input  logic       isSigned,
  input  logic [1:0] sel,
  input  logic       absMod,
  input  logic       negMod,
  input  logic [1:0] dstFmt,
  output i2fCtrl_t   strobes
);
  logic badSel;
  logic badFmt;

  always_comb begin
    badSel = ((srcFmt == SRC_B16) && sel[0]) ||
             ((srcFmt == SRC_B32) && (sel != 2'd0));
    badFmt = (srcFmt == SRC_B64) ||
             ((dstFmt != DST_HALF) && (dstFmt != DST_SINGLE));
    strobes.width8       = (srcFmt == SRC_B8);
    strobes.width16      = (srcFmt == SRC_B16);
    strobes.signExt      = isSigned;
    strobes.doAbs        = absMod;
    strobes.negAlways    = negMod && (absMod || !isSigned);
    strobes.negUnlessMin = negMod && isSigned && !absMod;
    strobes.halfOut      = (dstFmt == DST_HALF);
    strobes.illegal      = badSel || badFmt;
  end
endmodule

// File: rtl/i2f_round.sv
module i2f_round
  import i2f_pkg::*;
#(
  parameter int MANT_W = 23,
  parameter int EXP_W  = 8,
  parameter int IN_W   = 32,
  parameter int OUT_W  = 31
) (
  input  logic [IN_W-1:0]          norm,
  input  logic [$clog2(IN_W)-1:0]  lead,
  input  logic                     isZero,
  input  logic                     negSrc,
  input  logic [1:0]               rndMode,
  output logic [OUT_W-1:0]         bits
);
  localparam int KEEP_W   = MANT_W + 1;
  localparam int STICKY_W = IN_W - 2 - MANT_W;
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int LEAD_W   = $clog2(IN_W);

  logic [KEEP_W-1:0]       kept;
  logic                    guardBit;
  logic                    stickyBit;
  logic                    roundUp;
  logic                    awayZero;
  logic [KEEP_W:0]         sum;
  logic [9:0]              expUnb;
  logic [9:0]              expBiased;
  logic [EXP_W+MANT_W-1:0] packedVal;

  always_comb begin
    kept      = norm[IN_W-1 -: KEEP_W];
    guardBit  = norm[STICKY_W];
    stickyBit = |norm[STICKY_W-1:0];
    unique case (rndMode)
      RND_NEAR: roundUp = guardBit && (stickyBit || kept[0]);
      RND_DOWN: roundUp = negSrc && (guardBit || stickyBit);
      RND_UP:   roundUp = !negSrc && (guardBit || stickyBit);
      default:  roundUp = 1'b0;
    endcase
    awayZero  = (rndMode == RND_NEAR) ||
                ((rndMode == RND_DOWN) && negSrc) ||
                ((rndMode == RND_UP) && !negSrc);
    sum       = {1'b0, kept} + {{KEEP_W{1'b0}}, roundUp};
    expUnb    = 10'(lead) + {9'd0, sum[KEEP_W]};
    expBiased = expUnb + 10'(BIAS);
    if (isZero)
      packedVal = '0;
    else if (expUnb > 10'(BIAS))
      packedVal = awayZero ? {{EXP_W{1'b1}}, {MANT_W{1'b0}}}
                           : {{(EXP_W-1){1'b1}}, 1'b0, {MANT_W{1'b1}}};
    else
      packedVal = {expBiased[EXP_W-1:0], sum[MANT_W-1:0]};
    bits = OUT_W'(packedVal);
  end

  logic unusedLead;
  assign unusedLead = ^{lead[LEAD_W-1:0]};
endmodule

// File: rtl/i2f_datapath.sv
module i2f_datapath
  import i2f_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  i2fCtrl_t          strobes,
  input  logic [DATA_W-1:0] srcWord,
  input  logic [1:0]        sel,
  input  logic [1:0]        rndMode,
  output logic [DATA_W-1:0] result
);
  localparam int EXT_W  = DATA_W + 1;
  localparam int LEAD_W = $clog2(DATA_W);
  localparam int NFMT   = 2;

  logic [DATA_W-1:0] shifted;
  logic [EXT_W-1:0]  ext;
  logic [EXT_W-1:0]  minVal;
  logic [EXT_W-1:0]  val;
  logic [EXT_W-1:0]  negVal;
  logic              isMin;
  logic              negSrc;
  logic              flip;
  logic [DATA_W-1:0] mag;
  logic [LEAD_W-1:0] lead;
  logic [DATA_W-1:0] norm;
  logic              isZero;
  logic [DATA_W-2:0] rounded [NFMT];

  always_comb begin
    shifted = srcWord >> {sel, 3'b000};
    if (strobes.width8) begin
      ext    = strobes.signExt ? {{(EXT_W-8){shifted[7]}}, shifted[7:0]}
                               : {{(EXT_W-8){1'b0}}, shifted[7:0]};
      minVal = {{(EXT_W-7){1'b1}}, 7'd0};
    end else if (strobes.width16) begin
      ext    = strobes.signExt ? {{(EXT_W-16){shifted[15]}}, shifted[15:0]}
                               : {{(EXT_W-16){1'b0}}, shifted[15:0]};
      minVal = {{(EXT_W-15){1'b1}}, 15'd0};
    end else begin
      ext    = strobes.signExt ? {srcWord[DATA_W-1], srcWord} : {1'b0, srcWord};
      minVal = {2'b11, {(DATA_W-1){1'b0}}};
    end
    isMin  = strobes.signExt && (ext == minVal);
    val    = (strobes.doAbs && ext[EXT_W-1] && !isMin) ? (~ext + 1'b1) : ext;
    negSrc = val[EXT_W-1];
    negVal = ~val + 1'b1;
    mag    = negSrc ? negVal[DATA_W-1:0] : val[DATA_W-1:0];
    flip   = strobes.negAlways || (strobes.negUnlessMin && !isMin);
    isZero = (mag == '0);
    lead   = '0;
    for (int i = 0; i < DATA_W; i++)
      if (mag[i]) lead = LEAD_W'(i);
    norm   = mag << (LEAD_W'(DATA_W - 1) - lead);
  end

  for (genvar g = 0; g < NFMT; g++) begin : g_fmt
    localparam int MW = (g == 0) ? 10 : 23;
    localparam int EW = (g == 0) ? 5 : 8;
    i2f_round #(.MANT_W(MW), .EXP_W(EW), .IN_W(DATA_W), .OUT_W(DATA_W-1)) u_round (
      .norm(norm), .lead(lead), .isZero(isZero), .negSrc(negSrc),
      .rndMode(rndMode), .bits(rounded[g])
    );
  end

  always_comb begin
    if (strobes.illegal)
      result = '0;
    else if (strobes.halfOut)
      result = {{(DATA_W-16){1'b0}}, negSrc ^ flip, rounded[0][14:0]};
    else
      result = {negSrc ^ flip, rounded[1]};
  end
endmodule

// File: rtl/i2f_unit.sv
module i2f_unit
  import i2f_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] srcWord,
  input  logic [1:0]  srcFmt,
  input  logic        isSigned,
  input  logic [1:0]  sel,
  input  logic        absMod,
  input  logic        negMod,
  input  logic [1:0]  rndMode,
  input  logic [1:0]  dstFmt,
  output logic        outValid,
  output logic [31:0] result,
  output logic        illegalOp
);
  i2fCtrl_t    strobes;
  logic [31:0] resultNext;

  i2f_ctrl u_ctrl (
    .srcFmt(srcFmt), .isSigned(isSigned), .sel(sel), .absMod(absMod),
    .negMod(negMod), .dstFmt(dstFmt), .strobes(strobes)
  );

  i2f_datapath #(.DATA_W(32)) u_dp (
    .strobes(strobes), .srcWord(srcWord), .sel(sel), .rndMode(rndMode),
    .result(resultNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      result    <= '0;
      illegalOp <= 1'b0;
    end else begin
      outValid  <= inValid;
      result    <= inValid ? resultNext : '0;
      illegalOp <= inValid && strobes.illegal;
    end
  end
endmodule

// File: rtl/i2f_unit_chk.sv
module i2f_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [31:0] srcWord,
  input logic [1:0]  srcFmt,
  input logic        isSigned,
  input logic [1:0]  sel,
  input logic        absMod,
  input logic        negMod,
  input logic [1:0]  rndMode,
  input logic [1:0]  dstFmt,
  input logic        outValid,
  input logic [31:0] result,
  input logic        illegalOp
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r4_illegal_zero: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> (result == 32'd0));
  a_r3_word_sel: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && srcFmt == 2'd2 && sel != 2'd0) |=> illegalOp);
  a_r3_half_odd_sel: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && srcFmt == 2'd1 && sel[0]) |=> illegalOp);
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && dstFmt == 2'd1) |=> (result[31:16] == 16'd0));
  a_r11_zero_in: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && srcWord == 32'd0 && !negMod) |=> (result == 32'd0));
endmodule

bind i2f_unit i2f_unit_chk u_chk (.*);

// File: tb/sim_i2f_unit.sv
module sim_i2f_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NWORDS = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] srcWord = '0;
  logic [1:0]  srcFmt = '0;
  logic        isSigned = 1'b0;
  logic [1:0]  sel = '0;
  logic        absMod = 1'b0;
  logic        negMod = 1'b0;
  logic [1:0]  rndMode = '0;
  logic [1:0]  dstFmt = '0;
  logic        outValid;
  logic [31:0] result;
  logic        illegalOp;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2f_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcWord(srcWord),
    .srcFmt(srcFmt), .isSigned(isSigned), .sel(sel), .absMod(absMod),
    .negMod(negMod), .rndMode(rndMode), .dstFmt(dstFmt),
    .outValid(outValid), .result(result), .illegalOp(illegalOp)
  );

  function automatic logic [31:0] wordAt(input int i, input logic [31:0] lfsr);
    case (i)
      0:  return 32'h0000_0000;
      1:  return 32'h0000_0080;
      2:  return 32'h0000_00FF;
      3:  return 32'h0000_007F;
      4:  return 32'h0000_8000;
      5:  return 32'hFFFF_FFFF;
      6:  return 32'h8000_0000;
      7:  return 32'h7FFF_FFFF;
      8:  return 32'h00FF_FFFF;
      9:  return 32'h0100_0001;
      10: return 32'h0100_0003;
      11: return 32'h0000_0801;
      12: return 32'h0000_0803;
      13: return 32'h0000_FFF0;
      14: return 32'h0000_FFEF;
      15: return 32'h0001_0000;
      16: return 32'h80FF_7F01;
      17: return 32'h8000_8000;
      18: return 32'h0180_FF80;
      19: return 32'hFFF0_0001;
      20: return 32'h0000_0001;
      21: return 32'h0000_0FFF;
      22: return 32'h7F80_0180;
      23: return 32'hFFFF_8001;
      default: return lfsr;
    endcase
  endfunction

  function automatic logic [32:0] refConv(
      input logic [31:0] w, input int sf, input int sg, input int sl,
      input int ab, input int ng, input int rm, input int df, output string tag);
    longint wid, fld, v, mag, lo, q, r, hq, minv;
    int e, m, bias;
    bit isMin, neg, flip, up, inexact, away, sgn, ovf;
    longint bits;
    logic [31:0] res;
    if (sf == 3 || df == 0 || df == 3 || (sf == 1 && (sl % 2) == 1) ||
        (sf == 2 && sl != 0)) begin
      tag = "R4";
      return {1'b1, 32'd0};
    end
    wid = (sf == 0) ? 8 : (sf == 1) ? 16 : 32;
    fld = (longint'(w) >> (sl * 8)) & ((longint'(1) << wid) - 1);
    v = fld;
    if (sg != 0 && ((fld >> (wid - 1)) & 1) == 1) v = fld - (longint'(1) << wid);
    minv = -(longint'(1) << (wid - 1));
    isMin = (sg != 0) && (v == minv);
    if (ab != 0 && v < 0 && !isMin) v = -v;
    neg = (v < 0);
    mag = neg ? -v : v;
    flip = (ng != 0) && (ab != 0 || sg == 0 || !isMin);
    m = (df == 1) ? 10 : 23;
    bias = (df == 1) ? 15 : 127;
    inexact = 0;
    ovf = 0;
    if (mag == 0) bits = 0;
    else begin
      e = 40;
      while (((mag >> e) & 1) == 0) e--;
      if (e <= m) lo = mag << (m - e);
      else begin
        q = longint'(1) << (e - m);
        lo = mag / q;
        r = mag % q;
        hq = q / 2;
        inexact = (r != 0);
        case (rm)
          0: up = (r > hq) || (r == hq && (lo & 1) == 1);
          1: up = neg && r != 0;
          2: up = !neg && r != 0;
          default: up = 0;
        endcase
        lo = lo + longint'(up);
      end
      if (lo == (longint'(2) << m)) begin
        lo = lo >> 1;
        e++;
      end
      if (df == 1 && e > 15) begin
        ovf = 1;
        away = (rm == 0) || (rm == 1 && neg) || (rm == 2 && !neg);
        bits = away ? (longint'(31) << 10) : ((longint'(30) << 10) | 1023);
      end else
        bits = (longint'(e + bias) << m) | (lo - (longint'(1) << m));
    end
    sgn = neg ^ flip;
    if (df == 1) res = {16'd0, sgn, bits[14:0]};
    else res = {sgn, bits[30:0]};
    if (mag == 0) tag = "R11";
    else if (ovf) tag = "R10";
    else if (inexact) tag = "R8";
    else if (ng != 0) tag = (ab != 0 || sg == 0) ? "R6" : "R7";
    else if (ab != 0) tag = "R5";
    else if (sf != 0) tag = "R3";
    else if (df == 1) tag = "R9";
    else tag = "R2";
    return {1'b0, res};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    logic [32:0] exp;
    string tag;
    lfsr = 32'hACE1_2357;
    repeat (4) @(negedge clk);
    check("R1 reset valid", {31'd0, outValid}, 32'd0);
    check("R1 reset result", result, 32'd0);
    check("R1 reset illegal", {31'd0, illegalOp}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle valid", {31'd0, outValid}, 32'd0);
    for (int wi = 0; wi < NWORDS; wi++) begin
      logic [31:0] w;
      w = wordAt(wi, lfsr);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      for (int sf = 0; sf < 4; sf++)
      for (int sg = 0; sg < 2; sg++)
      for (int sl = 0; sl < 4; sl++)
      for (int ab = 0; ab < 2; ab++)
      for (int ng = 0; ng < 2; ng++)
      for (int rm = 0; rm < 4; rm++)
      for (int df = 0; df < 4; df++) begin
        inValid = 1'b1;
        srcWord = w;
        srcFmt = 2'(sf);
        isSigned = 1'(sg);
        sel = 2'(sl);
        absMod = 1'(ab);
        negMod = 1'(ng);
        rndMode = 2'(rm);
        dstFmt = 2'(df);
        exp = refConv(w, sf, sg, sl, ab, ng, rm, df, tag);
        @(negedge clk);
        checks++;
        if (!outValid || illegalOp !== exp[32] || result !== exp[31:0]) begin
          fails++;
          $display("FAIL %s: word %h fmt %0d s %0d sel %0d abs %0d neg %0d rnd %0d dst %0d actual %b/%b/%h expected 1/%b/%h",
                   tag, w, sf, sg, sl, ab, ng, rm, df, outValid, illegalOp, result,
                   exp[32], exp[31:0]);
        end
        if (df == 1) check("R9 upper half zero", {16'd0, result[31:16]}, 32'd0);
      end
    end
    inValid = 1'b0;
    @(negedge clk);
    check("R1 valid drops", {31'd0, outValid}, 32'd0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule